// File: doc/BRIEF.md
# Dual-Mode Serial Receiver

This block is one receive channel of a serial port. It takes characters in one of two ways. In framed asynchronous mode, a start bit opens the character and one or two stop bits close it, with an optional parity bit before the stops. In clocked synchronous mode, a serial clock that comes with the data marks each bit, and there is no framing. Both modes feed the same shift register. When a character is complete, it goes into a receive data register, and the block raises a full flag and a request line.

In asynchronous mode the block needs an oversampling tick from an external rate generator, at sixteen ticks per bit. It finds the start bit, confirms it at mid-bit, and then samples each later bit at its midpoint. Software reads the data register and then pulses a read strobe. Parity, framing and overrun errors stay set until the configuration pulses a flag-clear input. Clearing the receive enable drops any character in progress.

Top module: `dual_serial_rx`

## Requirements
- R1: After reset the data register is zero, and the full flag, all three error flags and the request line are low.
- R2: Asynchronous mode (syncMode=0) with sampleTick asserted:
  - A low line at a tick while idle is taken as a possible start bit.
  - The start bit is checked 8 ticks later.
  - Each data bit is then sampled every 16 ticks, least significant bit first.
  - The character length is dataLen+1 bits (dataLen 0 to 7).
- R3: When a character completes:
  - The data goes into rxData right-aligned, with the unused upper bits zero.
  - rxFull is set.
  - rxData changes at no other time.
- R4: A readStrobe pulse clears rxFull and leaves rxData unchanged.
- R5: Parity in asynchronous mode with parityEn=1:
  - One parity bit follows the data bits.
  - With parityOdd=0 the count of ones over the data and parity bits must be even. With parityOdd=1 it must be odd.
  - A mismatch sets parityErr when the character completes.
- R6: One stop bit is expected when twoStop=0 and two when twoStop=1. A stop bit sampled low sets frameErr.
- R7: A clearErr pulse clears parityErr, frameErr and overrunErr.
- R8: A character that completes while rxFull is still set (and no readStrobe comes in that cycle) sets overrunErr. The new data replaces the old data.
- R9: A start bit that reads high at its mid-bit check is dropped as a glitch: no character results. The next valid frame is received correctly.
- R10: Synchronous mode (syncMode=1):
  - Each rising edge of serialClk shifts in one bit.
  - After dataLen+1 bits (1 to 8) the character completes.
  - There is no start bit, parity bit or stop bit.
- R11: While rxEnable is low no character completes. A character that was in progress is abandoned, and rxData and rxFull keep their values.
- R12: rxIrq is high exactly when rxIntEnable is high and at least one of rxFull, parityErr, frameErr or overrunErr is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable; low aborts and holds idle |
| syncMode | input | 1 | 0 = framed asynchronous, 1 = clocked synchronous |
| sampleTick | input | 1 | Oversampling tick, 16 per bit time |
| serialClk | input | 1 | Serial clock for synchronous mode, in the clk domain |
| serialIn | input | 1 | Serial data line |
| dataLen | input | 3 | Character length minus one |
| parityEn | input | 1 | Parity bit present (asynchronous only) |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| twoStop | input | 1 | Two stop bits when set |
| clearErr | input | 1 | Pulse to clear the error flags |
| rxIntEnable | input | 1 | Receive request enable |
| readStrobe | input | 1 | Pulse after reading rxData; clears rxFull |
| rxData | output | 8 | Receive data register |
| rxFull | output | 1 | Unread character present |
| parityErr | output | 1 | Sticky parity error |
| frameErr | output | 1 | Sticky framing error |
| overrunErr | output | 1 | Sticky overrun error |
| rxIrq | output | 1 | Receive request |

## Verification
The assertions assume that syncMode, dataLen, parityEn, parityOdd and twoStop change only while the receiver is idle. They also assume that serialClk is already in the clk domain, and that clearErr and readStrobe never arrive in the same cycle as a completing character. The bench meets these assumptions in four ways:
- It changes the configuration only between whole characters.
- It drives serialClk on the falling edge of clk.
- It issues reads and clears only after the line has returned to idle.
- It holds sampleTick high, so that one bit time is exactly sixteen clocks.

// File: rtl/dsrx_pkg.sv
package dsrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } rxState_t;

  // Strobes from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic startChar;   // clear shift register and parity accumulator
    logic shiftBit;    // shift serialIn into the character
    logic parityBit;   // fold serialIn into the parity accumulator only
    logic finish;      // character complete: load data register
    logic stopLow;     // a stop bit of this character was low
  } rxStrobes_t;
endpackage

// File: rtl/dsrx_ctrl.sv
module dsrx_ctrl
  import dsrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int TICK_W = $clog2(OVERSAMPLE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             syncMode,
  input  logic             sampleTick,
  input  logic             serialClk,
  input  logic             serialIn,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             parityEn,
  input  logic             twoStop,
  output rxStrobes_t       strobes
);
  localparam logic [TICK_W-1:0] MID = TICK_W'(OVERSAMPLE / 2);

  rxState_t          state, stateNext;
  logic [TICK_W-1:0] tickCnt, tickNext;
  logic [LEN_W-1:0]  bitCnt, bitNext;
  logic              secondStop, secondNext;
  logic              stopBad, stopBadNext;
  logic              clkPrev;
  logic              clkRise, midPoint;

  assign clkRise  = serialClk & ~clkPrev;
  assign midPoint = sampleTick && (tickCnt == MID);

  always_comb begin
    stateNext   = state;
    tickNext    = tickCnt;
    bitNext     = bitCnt;
    secondNext  = secondStop;
    stopBadNext = stopBad;
    strobes     = '0;
    if (state != ST_IDLE && sampleTick) tickNext = tickCnt + 1'b1;
    case (state)
      ST_IDLE: begin
        if (syncMode) begin
          if (clkRise) begin
            strobes.startChar = 1'b1;
            strobes.shiftBit  = 1'b1;
            if (dataLen == '0) strobes.finish = 1'b1;
            else begin
              bitNext   = LEN_W'(1);
              stateNext = ST_DATA;
            end
          end
        end else if (sampleTick && !serialIn) begin
          tickNext  = TICK_W'(1);
          stateNext = ST_START;
        end
      end
      ST_START: begin
        if (midPoint) begin
          if (serialIn) stateNext = ST_IDLE;
          else begin
            strobes.startChar = 1'b1;
            bitNext   = '0;
            stateNext = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (syncMode ? clkRise : midPoint) begin
          strobes.shiftBit = 1'b1;
          if (bitCnt == dataLen) begin
            if (syncMode) begin
              strobes.finish = 1'b1;
              stateNext = ST_IDLE;
            end else begin
              secondNext  = 1'b0;
              stopBadNext = 1'b0;
              stateNext   = parityEn ? ST_PARITY : ST_STOP;
            end
          end else begin
            bitNext = bitCnt + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (midPoint) begin
          strobes.parityBit = 1'b1;
          stateNext = ST_STOP;
        end
      end
      ST_STOP: begin
        if (midPoint) begin
          if (twoStop && !secondStop) begin
            secondNext  = 1'b1;
            stopBadNext = stopBad | ~serialIn;
          end else begin
            strobes.finish  = 1'b1;
            strobes.stopLow = stopBad | ~serialIn;
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (!rxEnable) begin
      stateNext = ST_IDLE;
      strobes   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tickCnt    <= '0;
      bitCnt     <= '0;
      secondStop <= 1'b0;
      stopBad    <= 1'b0;
      clkPrev    <= 1'b0;
    end else begin
      state      <= stateNext;
      tickCnt    <= tickNext;
      bitCnt     <= bitNext;
      secondStop <= secondNext;
      stopBad    <= stopBadNext;
      clkPrev    <= serialClk;
    end
  end
endmodule

// File: rtl/dsrx_datapath.sv
module dsrx_datapath
  import dsrx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              syncMode,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              clearErr,
  input  logic              readStrobe,
  input  logic              rxIntEnable,
  input  rxStrobes_t        strobes,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr,
  output logic              rxIrq
);
  logic [DATA_W-1:0] shiftReg, shiftBase, shiftNext, aligned;
  logic              parAcc, accNext;
  logic [LEN_W:0]    shiftAmt;

  always_comb begin
    shiftBase = strobes.startChar ? '0 : shiftReg;
    shiftNext = strobes.shiftBit ? {serialIn, shiftBase[DATA_W-1:1]} : shiftBase;
    accNext   = (strobes.startChar ? 1'b0 : parAcc)
                ^ ((strobes.shiftBit | strobes.parityBit) & serialIn);
    shiftAmt  = (LEN_W+1)'(DATA_W - 1) - {1'b0, dataLen};
    aligned   = shiftNext >> shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      parAcc     <= 1'b0;
      rxData     <= '0;
      rxFull     <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      shiftReg <= shiftNext;
      parAcc   <= accNext;
      if (strobes.finish) begin
        rxData <= aligned;
        rxFull <= 1'b1;
      end else if (readStrobe) begin
        rxFull <= 1'b0;
      end
      if (strobes.finish && rxFull && !readStrobe) overrunErr <= 1'b1;
      else if (clearErr) overrunErr <= 1'b0;
      if (strobes.finish && parityEn && !syncMode && (accNext ^ parityOdd)) parityErr <= 1'b1;
      else if (clearErr) parityErr <= 1'b0;
      if (strobes.finish && strobes.stopLow) frameErr <= 1'b1;
      else if (clearErr) frameErr <= 1'b0;
    end
  end

  assign rxIrq = rxIntEnable & (rxFull | parityErr | frameErr | overrunErr);
endmodule

// File: rtl/dual_serial_rx.sv
module dual_serial_rx
  import dsrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              syncMode,
  input  logic              sampleTick,
  input  logic              serialClk,
  input  logic              serialIn,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              clearErr,
  input  logic              rxIntEnable,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr,
  output logic              rxIrq
);
  rxStrobes_t strobes;

  dsrx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk, .rstN, .rxEnable, .syncMode, .sampleTick, .serialClk, .serialIn,
    .dataLen, .parityEn, .twoStop, .strobes
  );

  dsrx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk, .rstN, .serialIn, .syncMode, .dataLen, .parityEn, .parityOdd,
    .clearErr, .readStrobe, .rxIntEnable, .strobes,
    .rxData, .rxFull, .parityErr, .frameErr, .overrunErr, .rxIrq
  );
endmodule

// File: rtl/dsrx_checker.sv
module dsrx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              clearErr,
  input logic              readStrobe,
  input logic              finish,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              parityErr,
  input logic              frameErr,
  input logic              overrunErr
);
  a_r3_data_only_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    !finish |=> $stable(rxData));

  a_r3_full_after_finish: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> rxFull);

  a_r4_read_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && !finish |=> !rxFull);

  a_r7_clear_errors: assert property (@(posedge clk) disable iff (!rstN)
    clearErr && !finish |=> !parityErr && !frameErr && !overrunErr);

  a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    finish && rxFull && !readStrobe |=> overrunErr);

  a_r11_no_finish_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> !finish);
endmodule

bind dual_serial_rx dsrx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk, .rstN, .rxEnable, .clearErr, .readStrobe,
  .finish(strobes.finish),
  .rxData, .rxFull, .parityErr, .frameErr, .overrunErr
);

// File: tb/test_dual_serial_rx.sv
module test_dual_serial_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, syncMode = 1'b0, sampleTick = 1'b1;
  logic serialClk = 1'b0, serialIn = 1'b1;
  logic [2:0] dataLen = 3'd7;
  logic parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic clearErr = 1'b0, rxIntEnable = 1'b0, readStrobe = 1'b0;
  logic [7:0] rxData;
  logic rxFull, parityErr, frameErr, overrunErr, rxIrq;
  int tests = 0, failed = 0;

  always #2 clk = ~clk;

  dual_serial_rx i_dual_serial_rx (
    .clk, .rstN, .rxEnable, .syncMode, .sampleTick, .serialClk, .serialIn,
    .dataLen, .parityEn, .parityOdd, .twoStop, .clearErr, .rxIntEnable,
    .readStrobe, .rxData, .rxFull, .parityErr, .frameErr, .overrunErr, .rxIrq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    serialIn = v;
    repeat (n) @(negedge clk);
  endtask

  // lowStop: last stop bit driven low for its first 9 clocks.
  task automatic sendAsync(input logic [7:0] d, input int len, input logic withPar,
                           input logic parVal, input logic lowStop);
    hold(1'b0, 16);
    for (int i = 0; i < len; i++) hold(d[i], 16);
    if (withPar) hold(parVal, 16);
    if (twoStop) hold(1'b1, 16);
    if (lowStop) begin hold(1'b0, 9); hold(1'b1, 7); end
    else hold(1'b1, 16);
    hold(1'b1, 4);
  endtask

  task automatic sendSync(input logic [7:0] d, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk) serialIn = d[i];
      @(negedge clk) serialClk = 1'b1;
      @(negedge clk);
      @(negedge clk) serialClk = 1'b0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic readOut();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge clk) clearErr = 1'b1;
    @(negedge clk) clearErr = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 data", 32'(rxData), 32'h0);
    chk("R1 flags", 32'({rxFull, parityErr, frameErr, overrunErr, rxIrq}), 32'h0);
  endtask

  task automatic testBasic();
    sendAsync(8'hA5, 8, 1'b0, 1'b0, 1'b0);
    chk("R2 async data", 32'(rxData), 32'hA5);
    chk("R3 full set", 32'(rxFull), 32'h1);
    chk("R3 no errors", 32'({parityErr, frameErr, overrunErr}), 32'h0);
    readOut();
    chk("R4 read clears full", 32'(rxFull), 32'h0);
    chk("R4 data kept", 32'(rxData), 32'hA5);
  endtask

  task automatic testShortLen();
    dataLen = 3'd4;
    sendAsync(8'hF6, 5, 1'b0, 1'b0, 1'b0);
    chk("R3 right aligned 5 bit", 32'(rxData), 32'h16);
    readOut();
    dataLen = 3'd7;
  endtask

  task automatic testParity();
    parityEn = 1'b1; parityOdd = 1'b0;
    sendAsync(8'h3C, 8, 1'b1, 1'b0, 1'b0);
    chk("R5 even ok", 32'({rxData, parityErr}), 32'({8'h3C, 1'b0}));
    readOut();
    parityOdd = 1'b1;
    sendAsync(8'h3C, 8, 1'b1, 1'b0, 1'b0);
    chk("R5 odd mismatch", 32'(parityErr), 32'h1);
    readOut();
    clearFlags();
    chk("R7 parity cleared", 32'(parityErr), 32'h0);
    dataLen = 3'd6;
    sendAsync(8'h55, 7, 1'b1, 1'b1, 1'b0);
    chk("R5 odd 7 bit ok", 32'({rxData, parityErr}), 32'({8'h55, 1'b0}));
    readOut();
    dataLen = 3'd7; parityEn = 1'b0; parityOdd = 1'b0;
  endtask

  task automatic testFraming();
    sendAsync(8'h81, 8, 1'b0, 1'b0, 1'b1);
    chk("R6 low stop", 32'({rxData, frameErr}), 32'({8'h81, 1'b1}));
    readOut();
    clearFlags();
    chk("R7 frame cleared", 32'(frameErr), 32'h0);
    twoStop = 1'b1;
    sendAsync(8'h42, 8, 1'b0, 1'b0, 1'b0);
    chk("R6 two stops ok", 32'({rxData, frameErr}), 32'({8'h42, 1'b0}));
    readOut();
    sendAsync(8'h24, 8, 1'b0, 1'b0, 1'b1);
    chk("R6 second stop low", 32'(frameErr), 32'h1);
    readOut();
    clearFlags();
    twoStop = 1'b0;
  endtask

  task automatic testOverrun();
    sendAsync(8'h11, 8, 1'b0, 1'b0, 1'b0);
    sendAsync(8'h22, 8, 1'b0, 1'b0, 1'b0);
    chk("R8 overrun set", 32'(overrunErr), 32'h1);
    chk("R8 new data kept", 32'(rxData), 32'h22);
    readOut();
    clearFlags();
    chk("R7 overrun cleared", 32'(overrunErr), 32'h0);
  endtask

  task automatic testGlitch();
    hold(1'b0, 3);
    hold(1'b1, 40);
    chk("R9 glitch rejected", 32'(rxFull), 32'h0);
    sendAsync(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    chk("R9 next frame ok", 32'(rxData), 32'h5A);
    readOut();
  endtask

  task automatic testSync();
    syncMode = 1'b1;
    dataLen = 3'd4;
    sendSync(8'h15, 5);
    chk("R10 sync 5 bit", 32'({rxFull, rxData}), 32'({1'b1, 8'h15}));
    readOut();
    dataLen = 3'd0;
    sendSync(8'h01, 1);
    chk("R10 sync 1 bit", 32'({rxFull, rxData}), 32'({1'b1, 8'h01}));
    readOut();
    dataLen = 3'd7;
    sendSync(8'hC3, 8);
    chk("R10 sync 8 bit", 32'({rxData, parityErr, frameErr}), 32'({8'hC3, 2'b00}));
    readOut();
    serialIn = 1'b1;
    syncMode = 1'b0;
  endtask

  task automatic testAbort();
    hold(1'b0, 16);
    hold(1'b1, 16);
    hold(1'b0, 16);
    rxEnable = 1'b0;
    hold(1'b1, 20);
    rxEnable = 1'b1;
    hold(1'b1, 200);
    chk("R11 aborted no char", 32'(rxFull), 32'h0);
    chk("R11 data unchanged", 32'(rxData), 32'hC3);
  endtask

  task automatic testIrq();
    rxIntEnable = 1'b1;
    @(negedge clk);
    chk("R12 idle no irq", 32'(rxIrq), 32'h0);
    sendAsync(8'h99, 8, 1'b0, 1'b0, 1'b0);
    chk("R12 irq on full", 32'(rxIrq), 32'h1);
    rxIntEnable = 1'b0;
    @(negedge clk);
    chk("R12 irq masked", 32'(rxIrq), 32'h0);
    readOut();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);
    testBasic();
    testShortLen();
    testParity();
    testFraming();
    testOverrun();
    testGlitch();
    testSync();
    testAbort();
    testIrq();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule